// File: doc/BRIEF.md
# I2C master with internal addressing

This block is a single-master two-wire serial bus controller for slaves that take a 7-bit address. It does one random-access transfer of one data byte per command. The target is a slave such as a serial memory, which expects an internal location of zero to three bytes after its device address. The requester places the device address, the internal location, the number of location bytes, the direction and the write byte on the command pins, then pulses the start strobe. The block runs the whole bus frame by itself. At the end it pulses a completion flag and presents the read byte and an acknowledge-error flag.

A read that carries an internal location has two phases. First a write phase sends the device address and the location bytes. A repeated START follows, and then the device address with the read bit. A read without a location goes straight to the read-direction address. The bus clock comes from a divider. Each clock period is split into four equal quarters of `QTR_CYCLES` system clocks. Both lines are open-drain: an output-enable of 1 pulls the line low, and 0 releases it.

Top module: `i2c_ia_master`

## Requirements
- R1: After reset both line enables are 0 (lines released), and `busy`, `rsp_done` and `rsp_nack` are 0.
- R2: A write sends START, then the byte {device address, 0}, then the location bytes, then the data byte, then STOP. Each of these bytes is followed by an acknowledge bit that the slave drives.
- R3: `cmd_ia_len` = n (0..3) sends exactly n location bytes, most significant first: `cmd_ia[8n-1:8n-8]` first and `cmd_ia[7:0]` last.
- R4: A read with n > 0 sends START, {address, 0}, the n location bytes, a repeated START, {address, 1}, receives one byte, answers NACK (SDA high) and sends STOP. Two START conditions appear.
- R5: A read with n = 0 sends START, {address, 1}, receives one byte, answers NACK and sends STOP. There is one START and no write phase.
- R6: The received byte is assembled MSB first and appears on `rsp_rdata` when `rsp_done` pulses.
- R7: The acknowledge is sampled while SCL is high in the ninth bit of each byte the master sends. If it is high, no further byte is sent, STOP follows, and `rsp_nack` is 1 from the `rsp_done` pulse until the next accepted command. It is 0 after a transfer that succeeds.
- R8: SDA changes only while SCL is low, except for the START, repeated START and STOP conditions. No spurious START or STOP appears.
- R9: Each SCL high phase inside a transfer lasts exactly 2*`QTR_CYCLES` system clocks.
- R10: `busy` is 1 from the cycle after the accepted strobe until `rsp_done`. `rsp_done` is a one-cycle pulse, given once per transfer.
- R11: A start strobe while `busy` is 1 is ignored: the running frame is unchanged and no extra transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_start | input | 1 | Start strobe, taken only while idle |
| cmd_dev | input | 7 | Slave device address |
| cmd_ia | input | 8*IA_BYTES | Internal location value |
| cmd_ia_len | input | clog2(IA_BYTES+1) | Number of location bytes to send |
| cmd_rd | input | 1 | 1 = read, 0 = write |
| cmd_wdata | input | 8 | Byte to write |
| rsp_rdata | output | 8 | Byte read from the slave |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_nack | output | 1 | Slave failed to acknowledge |
| busy | output | 1 | Transfer in progress |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sensed SDA level |

## Verification
The assertions check several rules on every cycle. SDA stays still across each data or acknowledge high phase. The acknowledge and read samples are taken only while SCL is released. The completion pulse lasts one cycle, and the error flag rises only with it. Command fields stay frozen while a transfer runs, and no byte follows a refused acknowledge. The frame content needs the bench's slave model to show it: the byte order for every location size in both directions, the repeated START, the final NACK, the read data, and the exact SCL high time.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // bit-level operations executed by the line engine
    typedef enum logic [1:0] {
        BOP_START,
        BOP_STOP,
        BOP_WR,
        BOP_RD
    } bop_e;

    // frame-level controller states
    typedef enum logic [2:0] {
        CS_IDLE,
        CS_START,
        CS_TX,
        CS_RX,
        CS_STOP
    } cst_e;

    // meaning of the byte currently being shifted out
    typedef enum logic [1:0] {
        BK_DEV,
        BK_IA,
        BK_DATA
    } bkind_e;

    localparam int BYTE_BITS = 8;
    localparam int DEV_BITS  = 7;

endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QTR_CYCLES = 125,
    localparam int CNT_W = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } qt_t;

    qt_t q, n;

    always_comb begin
        n    = q;
        tick = 1'b0;
        if (!en) begin
            n.cnt = '0;
        end else if (q.cnt == CNT_W'(QTR_CYCLES - 1)) begin
            n.cnt = '0;
            tick  = 1'b1;
        end else begin
            n.cnt = q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

endmodule

// File: rtl/i2cm_bitop.sv
module i2cm_bitop
    import i2cm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic op_valid,
    input  bop_e op_kind,
    input  logic op_bit,
    output logic op_ready,
    output logic op_fin,
    output logic rx_bit,
    output logic run,
    output logic scl_oe,
    output logic sda_oe,
    input  logic sda_in
);

    typedef struct packed {
        logic       run;
        logic [1:0] ph;
        bop_e       kind;
        logic       b;
        logic       scl_oe;
        logic       sda_oe;
        logic       rx;
    } bo_t;

    bo_t q, n;

    // line enables {scl_oe, sda_oe} for one quarter of one operation
    function automatic logic [1:0] lines(input bop_e k, input logic b, input logic [1:0] ph);
        logic [1:0] r;
        r = 2'b00;
        case (k)
            BOP_START: case (ph)
                2'd0: r = 2'b10;
                2'd1: r = 2'b00;
                2'd2: r = 2'b01;
                default: r = 2'b11;
            endcase
            BOP_STOP: case (ph)
                2'd0: r = 2'b11;
                2'd1: r = 2'b01;
                default: r = 2'b00;
            endcase
            BOP_WR: r = {(ph == 2'd0) || (ph == 2'd3), ~b};
            default: r = {(ph == 2'd0) || (ph == 2'd3), 1'b0};
        endcase
        return r;
    endfunction

    always_comb begin
        n      = q;
        op_fin = 1'b0;
        if (!q.run) begin
            if (op_valid) begin
                n.run               = 1'b1;
                n.ph                = 2'd0;
                n.kind              = op_kind;
                n.b                 = op_bit;
                {n.scl_oe, n.sda_oe} = lines(op_kind, op_bit, 2'd0);
            end
        end else if (tick) begin
            if (q.ph == 2'd2) n.rx = sda_in;
            if (q.ph == 2'd3) begin
                n.run  = 1'b0;
                op_fin = 1'b1;
            end else begin
                n.ph                 = q.ph + 2'd1;
                {n.scl_oe, n.sda_oe} = lines(q.kind, q.b, q.ph + 2'd1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign op_ready = !q.run;
    assign rx_bit   = q.rx;
    assign run      = q.run;
    assign scl_oe   = q.scl_oe;
    assign sda_oe   = q.sda_oe;

    // data and acknowledge bits keep SDA still across the SCL high phase
    p_sda_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && $past(q.run) && (q.kind == BOP_WR || q.kind == BOP_RD)
         && !q.scl_oe && !$past(q.scl_oe)) |-> $stable(q.sda_oe));

    // the bus is sampled only while SCL is released
    p_sample_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run && tick && q.ph == 2'd2) |-> !q.scl_oe);

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int IA_BYTES = 3,
    localparam int IA_W  = 8 * IA_BYTES,
    localparam int LEN_W = $clog2(IA_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_start,
    input  logic [DEV_BITS-1:0] cmd_dev,
    input  logic [IA_W-1:0]     cmd_ia,
    input  logic [LEN_W-1:0]    cmd_ia_len,
    input  logic                cmd_rd,
    input  logic [7:0]          cmd_wdata,
    output logic                op_valid,
    output bop_e                op_kind,
    output logic                op_bit,
    input  logic                op_ready,
    input  logic                op_fin,
    input  logic                rx_bit,
    output logic [7:0]          rsp_rdata,
    output logic                rsp_done,
    output logic                rsp_nack,
    output logic                busy
);

    typedef struct packed {
        cst_e                st;
        bkind_e              bk;
        logic [3:0]          bitn;
        logic [7:0]          sh;
        logic [LEN_W-1:0]    left;
        logic [IA_W-1:0]     ia;
        logic [DEV_BITS-1:0] dev;
        logic                rd;
        logic [7:0]          wdata;
        logic                rdphase;
        logic                err;
        logic                pend;
        logic [7:0]          rdata;
        logic                done;
        logic                nack;
    } ct_t;

    ct_t q, n;

    // location byte sent while 'left' bytes remain (most significant first)
    function automatic logic [7:0] ia_pick(input logic [IA_W-1:0] v, input logic [LEN_W-1:0] left);
        logic [7:0] b;
        b = '0;
        for (int k = 0; k < IA_BYTES; k++) begin
            if (left == LEN_W'(k + 1)) b = v[8*k +: 8];
        end
        return b;
    endfunction

    always_comb begin
        n        = q;
        n.done   = 1'b0;
        op_valid = 1'b0;
        op_kind  = BOP_START;
        op_bit   = 1'b1;
        case (q.st)
            CS_IDLE: begin
                if (cmd_start) begin
                    n.st    = CS_START;
                    n.dev   = cmd_dev;
                    n.ia    = cmd_ia;
                    n.rd    = cmd_rd;
                    n.wdata = cmd_wdata;
                    n.left  = (cmd_ia_len > LEN_W'(IA_BYTES)) ? LEN_W'(IA_BYTES) : cmd_ia_len;
                    n.err   = 1'b0;
                    n.nack  = 1'b0;
                    n.pend  = 1'b0;
                end
            end
            CS_START: begin
                op_valid = !q.pend;
                op_kind  = BOP_START;
                if (op_fin) begin
                    n.rdphase = q.rd && (q.left == '0);
                    n.sh      = {q.dev, q.rd && (q.left == '0)};
                    n.bk      = BK_DEV;
                    n.bitn    = '0;
                    n.st      = CS_TX;
                end
            end
            CS_TX: begin
                op_valid = !q.pend;
                op_kind  = (q.bitn == 4'd8) ? BOP_RD : BOP_WR;
                op_bit   = q.sh[7];
                if (op_fin) begin
                    if (q.bitn != 4'd8) begin
                        n.sh   = {q.sh[6:0], 1'b0};
                        n.bitn = q.bitn + 4'd1;
                    end else begin
                        n.bitn = '0;
                        if (rx_bit) begin
                            n.err = 1'b1;
                            n.st  = CS_STOP;
                        end else if (q.bk == BK_DATA) begin
                            n.st = CS_STOP;
                        end else if (q.rdphase) begin
                            n.st = CS_RX;
                        end else if (q.left != '0) begin
                            n.sh   = ia_pick(q.ia, q.left);
                            n.left = q.left - LEN_W'(1);
                            n.bk   = BK_IA;
                        end else if (q.rd) begin
                            n.st = CS_START;
                        end else begin
                            n.sh = q.wdata;
                            n.bk = BK_DATA;
                        end
                    end
                end
            end
            CS_RX: begin
                op_valid = !q.pend;
                op_kind  = (q.bitn == 4'd8) ? BOP_WR : BOP_RD;
                op_bit   = 1'b1;
                if (op_fin) begin
                    if (q.bitn != 4'd8) begin
                        n.sh   = {q.sh[6:0], rx_bit};
                        n.bitn = q.bitn + 4'd1;
                    end else begin
                        n.rdata = q.sh;
                        n.st    = CS_STOP;
                    end
                end
            end
            CS_STOP: begin
                op_valid = !q.pend;
                op_kind  = BOP_STOP;
                if (op_fin) begin
                    n.st   = CS_IDLE;
                    n.done = 1'b1;
                    n.nack = q.err;
                end
            end
            default: n.st = CS_IDLE;
        endcase
        if (op_valid && op_ready) n.pend = 1'b1;
        if (op_fin)               n.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign rsp_rdata = q.rdata;
    assign rsp_done  = q.done;
    assign rsp_nack  = q.nack;
    assign busy      = (q.st != CS_IDLE);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_nack_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_nack) |-> rsp_done);

    p_cmd_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_start) |=> ($stable(q.dev) && $stable(q.ia) && $stable(q.rd) && $stable(q.wdata)));

    p_stop_after_nack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && q.st != CS_IDLE) |-> q.st == CS_STOP);

    p_fin_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        op_fin |-> q.pend);

endmodule

// File: rtl/i2c_ia_master.sv
module i2c_ia_master
    import i2cm_pkg::*;
#(
    parameter int QTR_CYCLES = 125,
    parameter int IA_BYTES   = 3,
    localparam int IA_W  = 8 * IA_BYTES,
    localparam int LEN_W = $clog2(IA_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [6:0]       cmd_dev,
    input  logic [IA_W-1:0]  cmd_ia,
    input  logic [LEN_W-1:0] cmd_ia_len,
    input  logic             cmd_rd,
    input  logic [7:0]       cmd_wdata,
    output logic [7:0]       rsp_rdata,
    output logic             rsp_done,
    output logic             rsp_nack,
    output logic             busy,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_in
);

    logic tick;
    logic op_valid;
    bop_e op_kind;
    logic op_bit;
    logic op_ready;
    logic op_fin;
    logic rx_bit;
    logic eng_run;

    i2cm_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_qtick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (eng_run),
        .tick  (tick)
    );

    i2cm_bitop u_bitop (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .op_valid (op_valid),
        .op_kind  (op_kind),
        .op_bit   (op_bit),
        .op_ready (op_ready),
        .op_fin   (op_fin),
        .rx_bit   (rx_bit),
        .run      (eng_run),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe),
        .sda_in   (sda_in)
    );

    i2cm_ctrl #(.IA_BYTES(IA_BYTES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_dev    (cmd_dev),
        .cmd_ia     (cmd_ia),
        .cmd_ia_len (cmd_ia_len),
        .cmd_rd     (cmd_rd),
        .cmd_wdata  (cmd_wdata),
        .op_valid   (op_valid),
        .op_kind    (op_kind),
        .op_bit     (op_bit),
        .op_ready   (op_ready),
        .op_fin     (op_fin),
        .rx_bit     (rx_bit),
        .rsp_rdata  (rsp_rdata),
        .rsp_done   (rsp_done),
        .rsp_nack   (rsp_nack),
        .busy       (busy)
    );

endmodule

// File: tb/test_i2c_ia_master.sv
`timescale 1ns/1ps
module test_i2c_ia_master;

    localparam int QTR = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [6:0]  cmd_dev = '0;
    logic [23:0] cmd_ia = '0;
    logic [1:0]  cmd_ia_len = '0;
    logic        cmd_rd = 1'b0;
    logic [7:0]  cmd_wdata = '0;
    logic [7:0]  rsp_rdata;
    logic        rsp_done, rsp_nack, busy, scl_oe, sda_oe, sda_in;

    always #5 clk = ~clk;

    i2c_ia_master #(.QTR_CYCLES(QTR), .IA_BYTES(3)) i_i2c_ia_master (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_dev(cmd_dev),
        .cmd_ia(cmd_ia), .cmd_ia_len(cmd_ia_len), .cmd_rd(cmd_rd), .cmd_wdata(cmd_wdata),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_nack(rsp_nack), .busy(busy),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // ---------------- bus and slave model ----------------
    logic scl, sda, sl_drv;
    assign scl    = ~scl_oe;
    assign sda    = ~(sda_oe | sl_drv);
    assign sda_in = sda;

    logic       sl_clr = 1'b0;
    int         nack_at = -1;
    logic [7:0] sl_tx = '0;

    logic       scl_p, sda_p, xmit, is_rd_addr, m_ack;
    logic [7:0] sh, txsh;
    int         bc, frame_b, log_n, nstart, nstop, done_cnt;
    logic [7:0] log_b [0:15];

    always @(posedge clk) begin
        if (!rst_n || sl_clr) begin
            log_n <= 0; nstart <= 0; nstop <= 0; done_cnt <= 0; m_ack <= 1'b0;
        end
        if (!rst_n) begin
            scl_p <= 1'b1; sda_p <= 1'b1; sl_drv <= 1'b0; xmit <= 1'b0;
            bc <= 0; frame_b <= 0; is_rd_addr <= 1'b0; sh <= '0; txsh <= '0;
        end else begin
            scl_p <= scl; sda_p <= sda;
            if (rsp_done && !sl_clr) done_cnt <= done_cnt + 1;
            if (scl && scl_p && sda_p && !sda) begin
                if (!sl_clr) nstart <= nstart + 1;
                bc <= 0; frame_b <= 0; xmit <= 1'b0; sl_drv <= 1'b0;
            end else if (scl && scl_p && !sda_p && sda) begin
                if (!sl_clr) nstop <= nstop + 1;
                bc <= 0; frame_b <= 0; xmit <= 1'b0; sl_drv <= 1'b0;
            end else if (!scl_p && scl) begin
                if (!xmit && bc < 8) sh <= {sh[6:0], sda};
                if (xmit && bc == 8) m_ack <= sda;
                bc <= bc + 1;
            end else if (scl_p && !scl) begin
                if (!xmit) begin
                    if (bc == 8) begin
                        if (log_n < 16) log_b[log_n] <= sh;
                        log_n      <= log_n + 1;
                        sl_drv     <= (log_n != nack_at);
                        is_rd_addr <= (frame_b == 0) && sh[0] && (log_n != nack_at);
                    end
                    if (bc == 9) begin
                        bc <= 0; frame_b <= frame_b + 1; sl_drv <= 1'b0;
                        if (is_rd_addr) begin
                            xmit <= 1'b1; txsh <= sl_tx; sl_drv <= ~sl_tx[7];
                        end
                    end
                end else begin
                    if (bc >= 1 && bc <= 7) sl_drv <= ~txsh[7-bc];
                    if (bc == 8) sl_drv <= 1'b0;
                    if (bc == 9) begin bc <= 0; sl_drv <= 1'b0; end
                end
            end
        end
    end

    // ---------------- SCL high-time monitor ----------------
    logic mscl_p, hi_val;
    int   hi_len, hi_seen, hi_bad;
    always @(posedge clk) begin
        if (!rst_n) begin
            mscl_p <= 1'b1; hi_val <= 1'b0; hi_len <= 0; hi_seen <= 0; hi_bad <= 0;
        end else begin
            mscl_p <= scl;
            if (scl && !mscl_p) begin
                hi_len <= 1; hi_val <= 1'b1;
            end else if (scl) begin
                hi_len <= hi_len + 1;
                if (scl_p && !sda_p && sda) hi_val <= 1'b0;
            end else if (mscl_p && hi_val) begin
                hi_seen <= hi_seen + 1;
                if (hi_len != 2*QTR) hi_bad <= hi_bad + 1;
            end
        end
    end

    // ---------------- checking ----------------
    int total = 0;
    int bad   = 0;

    task automatic chk(input logic ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run(input logic [6:0] dev, input logic [23:0] ia, input int len, input logic rd,
                       input logic [7:0] wd, input logic [7:0] tx, input int nk, input logic poke);
        logic [7:0] exp_b [0:7];
        int nb, exp_n, exp_starts, guard;
        logic exp_nack;
        string rq;
        @(negedge clk);
        nack_at = nk; sl_tx = tx; sl_clr = 1'b1;
        @(negedge clk);
        sl_clr = 1'b0;
        cmd_dev = dev; cmd_ia = ia; cmd_ia_len = 2'(len); cmd_rd = rd; cmd_wdata = wd;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        chk(busy == 1'b1, "R10", "busy after strobe", int'(busy), 1);
        guard = 0;
        while (!rsp_done && guard < 20000) begin
            @(negedge clk);
            guard++;
            cmd_start = poke && (guard == 40);
            if (poke && guard == 40) begin
                cmd_dev = ~dev; cmd_rd = ~rd; cmd_wdata = ~wd; cmd_ia_len = 2'(3 - len);
            end
        end
        cmd_start = 1'b0;
        chk(rsp_done == 1'b1, "R10", "done seen", int'(rsp_done), 1);
        chk(busy == 1'b0, "R10", "busy low at done", int'(busy), 0);
        repeat (poke ? 400 : 12) @(negedge clk);
        chk(done_cnt == 1, poke ? "R11" : "R10", "done pulses", done_cnt, 1);
        if (poke) chk(busy == 1'b0, "R11", "no second transfer", int'(busy), 0);

        nb = 0;
        exp_b[nb] = {dev, rd && (len == 0)}; nb++;
        if (!(rd && len == 0)) begin
            for (int k = len - 1; k >= 0; k--) begin exp_b[nb] = ia[8*k +: 8]; nb++; end
            if (rd) begin exp_b[nb] = {dev, 1'b1}; nb++; end
            else    begin exp_b[nb] = wd;          nb++; end
        end
        if (nk >= 0 && nk < nb) begin exp_n = nk + 1; exp_nack = 1'b1; end
        else                    begin exp_n = nb;     exp_nack = 1'b0; end
        exp_starts = (rd && len > 0 && exp_n > len + 1) ? 2 : 1;
        rq = rd ? ((len > 0) ? "R4" : "R5") : "R2";

        chk(log_n == exp_n, rq, "byte count", log_n, exp_n);
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk(log_b[i] == exp_b[i], "R3", $sformatf("byte %0d (len %0d rd %0d)", i, len, rd),
                int'(log_b[i]), int'(exp_b[i]));
        chk(nstart == exp_starts, "R8", $sformatf("%s start count", rq), nstart, exp_starts);
        chk(nstop == 1, "R8", "stop count", nstop, 1);
        chk(rsp_nack == exp_nack, "R7", "nack flag", int'(rsp_nack), int'(exp_nack));
        if (rd && !exp_nack) begin
            chk(rsp_rdata == tx, "R6", "read data", int'(rsp_rdata), int'(tx));
            chk(m_ack == 1'b1, rq, "final NACK from master", int'(m_ack), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released in reset", {scl_oe, sda_oe}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && rsp_done == 1'b0 && rsp_nack == 1'b0, "R1", "idle outputs",
            {busy, rsp_done, rsp_nack}, 0);
        chk(scl_oe == 1'b0 && sda_oe == 1'b0, "R1", "lines released idle", {scl_oe, sda_oe}, 0);

        // sweep: every location size, both directions, two value patterns
        for (int p = 0; p < 2; p++)
            for (int r = 0; r < 2; r++)
                for (int l = 0; l < 4; l++)
                    run(7'(7'h2A + 13*(l + 4*r + 8*p)),
                        (p != 0) ? (24'h5A3C96 ^ 24'(l * 24'h010101)) : (24'hA5C3E1 + 24'(l)),
                        l, r[0], (p != 0) ? 8'hC3 : 8'h3C, 8'(8'h96 + 17*l + 5*p + 64*r), -1, 1'b0);

        // refused acknowledges: device, middle location byte, data, read address
        run(7'h50, 24'h123456, 2, 1'b0, 8'hAB, 8'h00, 0, 1'b0);
        run(7'h50, 24'h123456, 2, 1'b0, 8'hAB, 8'h00, 2, 1'b0);
        run(7'h50, 24'h123456, 2, 1'b0, 8'hAB, 8'h00, 3, 1'b0);
        run(7'h33, 24'h0000F0, 1, 1'b1, 8'h00, 8'h5D, 2, 1'b0);
        run(7'h33, 24'h000000, 0, 1'b1, 8'h00, 8'h5D, 0, 1'b0);
        // a good transfer right after a refused one clears the flag
        run(7'h33, 24'h0000F0, 1, 1'b1, 8'h00, 8'hE7, -1, 1'b0);

        // strobe during a running transfer
        run(7'h21, 24'h00004C, 1, 1'b0, 8'h81, 8'h00, -1, 1'b1);

        chk(hi_seen > 0 && hi_bad == 0, "R9", "SCL high phases off 2*QTR", hi_bad, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule